// File: doc/BRIEF.md
# Interrupt Priority Level Selector

This block decides, at each instruction boundary, whether the processor takes an interrupt, and if so, which one. It scans the priority levels that lie strictly above the current processor priority, from the highest level downwards. At each level it weighs a programmed (software-raised) interrupt request against an external bus request from a peripheral. The first level that holds a request wins. The result is a one-cycle dispatch pulse, the vector to dispatch through and, when a bus source wins, an acknowledge to that source and a wake strobe for a processor idling in its wait state.

Two further rules apply after the scan. If no level has a request, the encoded level field of the programmed-request register is compared with the processor priority, and a higher field still dispatches to the programmed-interrupt vector. No selection takes place while the processor is halted or while any trap request is pending, because traps are served first. Fetching through the vector and arbitrating between traps happen outside this block.

Top module: `ipl_select`

## Requirements
- R1: While `rstN` is low, and in the cycle after it is released, `takeIrq`, `wake`, `busAck` and `vecOut` are all zero.
- R2: No interrupt is taken (`takeIrq` stays 0) unless `boundary` is high, `halted` is low and `trapPending` is low in the cycle before.
- R3: Only levels L with 1 <= L <= 7 and L > `pswPri` are eligible. Among eligible levels, the highest one holding a request wins.
- R4: At one level L, the programmed request bit `pirqReg[8+L]` is served in preference to the bus request `busReq[L]`.
- R5: A programmed interrupt that wins the scan dispatches to vector 16'h00A0 and raises no `busAck` bit.
- R6: A bus request at level L that wins dispatches to `busVec[16*L +: 16]` and raises only `busAck[L]`. `busReq[0]` is never served.
- R7: `wake` is high exactly when a bus interrupt is taken (`takeIrq` with a nonzero `busAck`).
- R8: When the scan finds nothing and the field `pirqReg[3:1]` is greater than `pswPri`, vector 16'h00A0 is taken with no `busAck`.
- R9: The outputs are registered one cycle after the boundary cycle. They last a single cycle per boundary, and at most one interrupt (one `busAck` bit) is dispatched per boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| boundary | input | 1 | Instruction boundary: evaluate this cycle |
| halted | input | 1 | Processor halted; suppresses selection |
| trapPending | input | 1 | A trap request is pending; suppresses selection |
| pswPri | input | 3 | Current processor priority |
| pirqReg | input | 16 | Programmed request register: bits 15:9 request levels 7..1, bits 3:1 encoded level |
| busReq | input | 8 | External request per level (bit 0 unused) |
| busVec | input | 128 | Vector per level, level L in bits 16*L+15 : 16*L |
| takeIrq | output | 1 | Interrupt taken pulse |
| vecOut | output | 16 | Vector to dispatch, valid with takeIrq |
| busAck | output | 8 | One-hot acknowledge to the winning bus level |
| wake | output | 1 | Leave wait state: a bus interrupt was taken |

## Verification
The assertions assume that `busReq` and `busVec` are stable for the boundary cycle they are sampled in. They also assume that `pswPri` describes the same boundary as the requests. The bench meets these conditions by changing every input only on the falling edge, one boundary at a time, and it drops `boundary` between evaluations. The sweep covers every priority against every bus request pattern. Programmed-request bits and level fields are derived from the loop indices so that ties, empty scans and fallback cases all occur. The vector values are kept distinct from 16'h00A0 so that programmed and bus dispatches cannot be confused.

// File: rtl/ipl_pkg.sv
package ipl_pkg;
  localparam int LVL_W = 3;
  localparam int LEVELS = 1 << LVL_W;
  localparam int PIRQ_BASE = 8;
  localparam int PIRQ_W = PIRQ_BASE + LEVELS;
  localparam int FIELD_LSB = 1;

  typedef struct packed {
    logic take;
    logic fromBus;
    logic [LVL_W-1:0] level;
  } iplStrobe_t;
endpackage

// File: rtl/ipl_ctrl.sv
module ipl_ctrl
  import ipl_pkg::*;
(
  input  logic              boundary,
  input  logic              halted,
  input  logic              trapPending,
  input  logic [LVL_W-1:0]  pswPri,
  input  logic [PIRQ_W-1:0] pirqReg,
  input  logic [LEVELS-1:0] busReq,
  output iplStrobe_t        strobe
);
  logic found;
  logic enable;
  logic [LVL_W-1:0] pirqField;

  assign enable = boundary && !halted && !trapPending;
  assign pirqField = pirqReg[FIELD_LSB +: LVL_W];

  always_comb begin
    strobe = '0;
    found = 1'b0;
    if (enable) begin
      for (int lv = LEVELS - 1; lv >= 1; lv--) begin
        if (!found && (LVL_W'(lv) > pswPri)) begin
          if (pirqReg[PIRQ_BASE + lv]) begin
            found = 1'b1;
            strobe.take = 1'b1;
            strobe.fromBus = 1'b0;
            strobe.level = LVL_W'(lv);
          end else if (busReq[lv]) begin
            found = 1'b1;
            strobe.take = 1'b1;
            strobe.fromBus = 1'b1;
            strobe.level = LVL_W'(lv);
          end
        end
      end
      if (!found && (pirqField > pswPri)) begin
        strobe.take = 1'b1;
        strobe.fromBus = 1'b0;
        strobe.level = pirqField;
      end
    end
  end
endmodule

// File: rtl/ipl_dp.sv
module ipl_dp
  import ipl_pkg::*;
#(
  parameter int VEC_W = 16,
  parameter logic [VEC_W-1:0] PIRQ_VEC = 16'h00A0
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  iplStrobe_t              strobe,
  input  logic [LEVELS*VEC_W-1:0] busVec,
  output logic                    takeIrq,
  output logic [VEC_W-1:0]        vecOut,
  output logic [LEVELS-1:0]       busAck,
  output logic                    wake
);
  logic [VEC_W-1:0] vecTable [LEVELS];
  logic [LEVELS-1:0] ackNext;
  logic [VEC_W-1:0] vecNext;

  for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
    assign vecTable[g] = busVec[g*VEC_W +: VEC_W];
    assign ackNext[g] = strobe.take && strobe.fromBus && (strobe.level == LVL_W'(g));
  end

  always_comb begin
    vecNext = '0;
    if (strobe.take) vecNext = strobe.fromBus ? vecTable[strobe.level] : PIRQ_VEC;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      takeIrq <= 1'b0;
      vecOut <= '0;
      busAck <= '0;
      wake <= 1'b0;
    end else begin
      takeIrq <= strobe.take;
      vecOut <= vecNext;
      busAck <= ackNext;
      wake <= strobe.take && strobe.fromBus;
    end
  end

  // R9
  single_ack_chk: assert property (@(posedge clk) disable iff (!rstN) $onehot0(busAck));
  // R7
  wake_bus_chk: assert property (@(posedge clk) disable iff (!rstN) wake == (takeIrq && busAck != '0));
endmodule

// File: rtl/ipl_select.sv
module ipl_select
  import ipl_pkg::*;
#(
  parameter int VEC_W = 16,
  parameter logic [VEC_W-1:0] PIRQ_VEC = 16'h00A0
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    boundary,
  input  logic                    halted,
  input  logic                    trapPending,
  input  logic [LVL_W-1:0]        pswPri,
  input  logic [PIRQ_W-1:0]       pirqReg,
  input  logic [LEVELS-1:0]       busReq,
  input  logic [LEVELS*VEC_W-1:0] busVec,
  output logic                    takeIrq,
  output logic [VEC_W-1:0]        vecOut,
  output logic [LEVELS-1:0]       busAck,
  output logic                    wake
);
  iplStrobe_t strobe;

  ipl_ctrl u_ctrl (
    .boundary(boundary), .halted(halted), .trapPending(trapPending),
    .pswPri(pswPri), .pirqReg(pirqReg), .busReq(busReq), .strobe(strobe)
  );

  ipl_dp #(.VEC_W(VEC_W), .PIRQ_VEC(PIRQ_VEC)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busVec(busVec),
    .takeIrq(takeIrq), .vecOut(vecOut), .busAck(busAck), .wake(wake)
  );

  // R2
  gated_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    takeIrq |-> $past(boundary && !halted && !trapPending));
  // R5
  pirq_vec_chk: assert property (@(posedge clk) disable iff (!rstN)
    (takeIrq && busAck == '0) |-> vecOut == PIRQ_VEC);
  // R3
  above_pri_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busAck & ((LEVELS'(2) << $past(pswPri)) - LEVELS'(1))) == '0);
  // R6
  ack_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busAck & ~$past(busReq)) == '0);
  // R9
  ack_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busAck != '0) |-> takeIrq);
endmodule

// File: tb/ipl_select_test.sv
module ipl_select_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic boundary = 1'b0, halted = 1'b0, trapPending = 1'b0;
  logic [2:0] pswPri = '0;
  logic [15:0] pirqReg = '0;
  logic [7:0] busReq = '0;
  logic [127:0] busVec;
  logic takeIrq, wake;
  logic [15:0] vecOut;
  logic [7:0] busAck;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  for (genvar g = 0; g < 8; g++) begin : g_vec
    assign busVec[g*16 +: 16] = 16'h0200 + 16'(g * 8);
  end

  ipl_select uut (
    .clk(clk), .rstN(rstN), .boundary(boundary), .halted(halted),
    .trapPending(trapPending), .pswPri(pswPri), .pirqReg(pirqReg),
    .busReq(busReq), .busVec(busVec), .takeIrq(takeIrq), .vecOut(vecOut),
    .busAck(busAck), .wake(wake)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // kind: 0 none, 1 pirq scan, 2 bus, 3 field fallback
  task automatic model(input logic [2:0] pri, input logic [15:0] pq, input logic [7:0] rq,
                       output int kind, output logic [15:0] vec, output logic [7:0] ack);
    kind = 0; vec = '0; ack = '0;
    for (int lv = 7; lv > pri; lv--) begin
      if (kind == 0) begin
        if (pq[8+lv]) begin kind = 1; vec = 16'h00A0; end
        else if (rq[lv]) begin kind = 2; vec = 16'h0200 + 16'(lv * 8); ack = 8'(1 << lv); end
      end
    end
    if (kind == 0 && pq[3:1] > pri) begin kind = 3; vec = 16'h00A0; end
  endtask

  task automatic evalOnce(input logic [2:0] pri, input logic [15:0] pq, input logic [7:0] rq);
    int kind;
    logic [15:0] ev;
    logic [7:0] ea;
    string vtag;
    model(pri, pq, rq, kind, ev, ea);
    @(negedge clk);
    pswPri = pri; pirqReg = pq; busReq = rq; boundary = 1'b1;
    @(negedge clk);
    boundary = 1'b0;
    vtag = (kind == 2) ? "R6" : (kind == 1) ? "R5" : (kind == 3) ? "R8" : "R3";
    chk(takeIrq == (kind != 0), "R3 take", 32'(takeIrq), 32'(kind != 0));
    chk(kind == 0 || vecOut == ev, {vtag, " vector"}, 32'(vecOut), 32'(ev));
    chk(busAck == ea, "R6 ack", 32'(busAck), 32'(ea));
    chk(wake == (kind == 2), "R7 wake", 32'(wake), 32'(kind == 2));
    @(negedge clk);
    chk(!takeIrq && busAck == '0 && !wake, "R9 pulse", {23'd0, takeIrq, busAck}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(!takeIrq && !wake && busAck == '0 && vecOut == '0, "R1 reset", {7'd0, wake, takeIrq, vecOut[6:0], busAck, 8'd0}, 32'd0);
    boundary = 1'b1; busReq = 8'hFE; pirqReg = 16'hFF0E;
    @(negedge clk);
    rstN = 1'b1; boundary = 1'b0;
    @(negedge clk);
    chk(!takeIrq && !wake && busAck == '0 && vecOut == '0, "R1 after release", {23'd0, takeIrq, busAck}, 32'd0);

    // R4 directed: level 5 both sources, programmed wins
    evalOnce(3'd0, 16'h2000, 8'h20);
    // R3 directed: request at level equal to priority ignored
    evalOnce(3'd4, 16'h0000, 8'h10);
    // R6 directed: level 0 bus request never served
    evalOnce(3'd0, 16'h0000, 8'h01);
    // R8 directed: field 6 above priority 2 with empty scan
    evalOnce(3'd2, 16'h000C, 8'h00);

    // R2: halted, trap pending, no boundary
    for (int m = 0; m < 3; m++) begin
      @(negedge clk);
      pswPri = 3'd0; pirqReg = 16'hFE0E; busReq = 8'hFE;
      boundary = (m != 2); halted = (m == 0); trapPending = (m == 1);
      @(negedge clk);
      chk(!takeIrq && busAck == '0 && !wake, "R2 gated", {23'd0, takeIrq, busAck}, 32'd0);
      boundary = 1'b0; halted = 1'b0; trapPending = 1'b0;
    end

    // Sweep: every priority against every bus request pattern
    for (int p = 0; p < 8; p++) begin
      for (int r = 0; r < 256; r++) begin
        logic [7:0] hi;
        logic [2:0] fld;
        hi = (r % 3 == 0) ? 8'h00 : 8'((r * 53 + p * 29) & 8'hFE);
        fld = (r % 4 == 1) ? 3'((r >> 2) + p) : 3'd0;
        evalOnce(3'(p), {hi, 4'b0000, fld, 1'b0}, 8'(r));
      end
    end
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule